// File: doc/BRIEF.md
# Vector Nonzero-Index Compressor

This block scans one vector register, streamed in element by element, under a programmable vector length. It builds a mask with one bit per element position, set wherever the element is nonzero. Alongside the mask it emits the positions of those nonzero elements as write requests into a destination vector. The positions are packed from destination element 0 upward with no gaps. A later gather can use that destination vector directly as an index list.

A run begins with a `start` strobe that carries the vector length. The block then takes one source element on every cycle in which `elem_valid` is high, and it may be stalled by leaving `elem_valid` low. When the last element inside the vector length has been consumed, the block raises `done` for one cycle and presents the number of indices written.

The controller has three named states:
- `ST_IDLE` waits for `start`. It moves to `ST_RUN`, or straight to `ST_FINISH` when the length is zero.
- `ST_RUN` consumes elements. It moves to `ST_FINISH` on the valid cycle of the last element.
- `ST_FINISH` pulses `done` and always returns to `ST_IDLE`.

Top module: `vmask_compress`

## Requirements
- R1: `mask_out` is 64 bits wide. Bit i is 1 exactly when source element i (i below the vector length) is nonzero. Bits at or above the vector length are 0 after the run.
- R2: For the elements 0, -1, 0, 5, -15, 0, 0, 24, -7, 13, 0, -17, 0, 0 under length 14, the destination receives 1, 3, 4, 7, 8, 9, 11 in that order, and `count` is 7.
- R3: Write number k of a run (k from 0) goes to destination address `wr_addr` = k. The written indices rise strictly within a run. Destination entries at and above `count` receive no write.
- R4: `wr_en` is high only in a cycle where `elem_valid` is high during a run and `elem_data` is nonzero. In that same cycle, `wr_idx` is the position of that element.
- R5: `done` is a one-cycle pulse. It appears in the cycle after the last element is accepted, and `count` then equals the number of ones in `mask_out`.
- R6: A start with vector length 0 gives `done` in the very next cycle, with `count` 0, `mask_out` 0 and no write.
- R7: `start` is ignored while a run is in progress, and the run finishes with the results of the original length.
- R8: Cycles with `elem_valid` low consume no element and change neither the mask nor the destination.
- R9: A vector length of 64 with all elements nonzero yields `count` 64, an all-ones mask and indices 0 to 63.
- R10: After reset, `mask_out` is 0 and neither `wr_en` nor `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run with length `vlen` (taken only when idle) |
| vlen | input | 7 | Vector length, 0 to 64 |
| elem_valid | input | 1 | Source element present this cycle |
| elem_data | input | 64 | Source element value |
| mask_out | output | 64 | Nonzero mask, one bit per element position |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | 6 | Destination element written |
| wr_idx | output | 6 | Index value written (source position) |
| done | output | 1 | One-cycle completion pulse |
| count | output | 7 | Number of indices written in the run |

## Verification
The assertions take two things for granted about the inputs. First, `vlen` never exceeds 64. Second, `elem_valid` is used only between an accepted start and the last element; a valid outside a run is never counted, and writes are expected only while the checker sees a run open. The stimulus keeps `vlen` within 0 to 64 and raises `elem_valid` exactly as many times as the length asks. It re-raises `start` in mid-run only in the cycles that test R7, and it drops `elem_valid` in random gap cycles to exercise stalling.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } vmc_state_e;
endpackage

// File: rtl/vmc_nz_test.sv
// Nonzero detector for one element, reduced in fixed-size slices.
module vmc_nz_test #(
    parameter int ELEM_W  = 64,
    parameter int SLICE_W = 16
) (
    input  logic [ELEM_W-1:0] data,
    output logic              nonzero
);
    localparam int NSLICE = (ELEM_W + SLICE_W - 1) / SLICE_W;
    localparam int PAD_W  = NSLICE * SLICE_W;

    logic [PAD_W-1:0]  padded;
    logic [NSLICE-1:0] slice_any;

    assign padded = PAD_W'(data);

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        assign slice_any[s] = |padded[s*SLICE_W +: SLICE_W];
    end

    assign nonzero = |slice_any;
endmodule

// File: rtl/vmc_mask_reg.sv
// Mask register: cleared at the start of a run, one bit set per nonzero element.
module vmc_mask_reg #(
    parameter int MAX_LEN = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_pos,
    output logic [MAX_LEN-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (clear) begin
            mask <= '0;
        end else if (set_en) begin
            mask[set_pos] <= 1'b1;
        end
    end
endmodule

// File: rtl/vmc_fsm.sv
// Run controller: sequencing, element position and write count.
module vmc_fsm
    import vmc_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int LEN_W   = 7,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] vlen,
    input  logic             elem_valid,
    input  logic             elem_nz,
    output logic             clear,
    output logic             set_en,
    output logic             done,
    output logic [IDX_W-1:0] pos,
    output logic [LEN_W-1:0] cnt
);
    vmc_state_e       state, nxt;
    logic [LEN_W-1:0] len_q, pos_q, cnt_q;
    logic             take, last;

    assign take = (state == ST_RUN) && elem_valid;
    assign last = (pos_q == len_q - LEN_W'(1));

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = (vlen == '0) ? ST_FINISH : ST_RUN;
            ST_RUN:    if (take && last) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            pos_q <= '0;
            cnt_q <= '0;
        end else if (state == ST_IDLE && start) begin
            len_q <= vlen;
            pos_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            pos_q <= pos_q + LEN_W'(1);
            if (elem_nz) cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        clear  = (state == ST_IDLE) && start;
        set_en = take && elem_nz;
        done   = (state == ST_FINISH);
        pos    = pos_q[IDX_W-1:0];
        cnt    = cnt_q;
    end
endmodule

// File: rtl/vmask_compress.sv
module vmask_compress #(
    parameter int MAX_LEN = 64,
    parameter int ELEM_W  = 64,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   vlen,
    input  logic               elem_valid,
    input  logic [ELEM_W-1:0]  elem_data,
    output logic [MAX_LEN-1:0] mask_out,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_addr,
    output logic [IDX_W-1:0]   wr_idx,
    output logic               done,
    output logic [LEN_W-1:0]   count
);
    logic             nz, clear, set_en;
    logic [IDX_W-1:0] pos;
    logic [LEN_W-1:0] cnt;

    vmc_nz_test #(.ELEM_W(ELEM_W)) u_nz (
        .data    (elem_data),
        .nonzero (nz)
    );

    vmc_fsm #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vlen       (vlen),
        .elem_valid (elem_valid),
        .elem_nz    (nz),
        .clear      (clear),
        .set_en     (set_en),
        .done       (done),
        .pos        (pos),
        .cnt        (cnt)
    );

    vmc_mask_reg #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .set_en  (set_en),
        .set_pos (pos),
        .mask    (mask_out)
    );

    assign wr_en   = set_en;
    assign wr_addr = cnt[IDX_W-1:0];
    assign wr_idx  = pos;
    assign count   = cnt;
endmodule

// File: rtl/vmc_checker.sv
module vmc_checker #(
    parameter int MAX_LEN = 64,
    parameter int ELEM_W  = 64,
    parameter int LEN_W   = 7,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [LEN_W-1:0]   vlen,
    input logic               elem_valid,
    input logic [ELEM_W-1:0]  elem_data,
    input logic [MAX_LEN-1:0] mask_out,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_addr,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               done,
    input logic [LEN_W-1:0]   count
);
    logic             busy_c;
    logic [LEN_W-1:0] wr_seen;
    logic [IDX_W-1:0] last_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c   <= 1'b0;
            wr_seen  <= '0;
            last_idx <= '0;
        end else begin
            if (start && !busy_c) begin
                busy_c  <= 1'b1;
                wr_seen <= '0;
            end else if (done) begin
                busy_c <= 1'b0;
            end
            if (wr_en) begin
                wr_seen  <= wr_seen + LEN_W'(1);
                last_idx <= wr_idx;
            end
        end
    end

    a_r4_write_needs_element: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (elem_valid && elem_data != '0));

    a_r4_no_write_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> !wr_en);

    a_r3_packed_address: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == wr_seen[IDX_W-1:0]));

    a_r3_ascending_index: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_seen != '0) |-> (wr_idx > last_idx));

    a_r5_count_is_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == LEN_W'($countones(mask_out))));

    a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_c && vlen == '0) |=> (done && count == '0 && mask_out == '0));
endmodule

bind vmask_compress vmc_checker #(
    .MAX_LEN(MAX_LEN), .ELEM_W(ELEM_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vlen       (vlen),
    .elem_valid (elem_valid),
    .elem_data  (elem_data),
    .mask_out   (mask_out),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_idx     (wr_idx),
    .done       (done),
    .count      (count)
);

// File: tb/sim_vmask_compress.sv
module sim_vmask_compress;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vlen = '0;
    logic        elem_valid = 1'b0;
    logic [63:0] elem_data = '0;
    logic [63:0] mask_out;
    logic        wr_en, done;
    logic [5:0]  wr_addr, wr_idx;
    logic [6:0]  count;

    vmask_compress u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
        .elem_valid(elem_valid), .elem_data(elem_data), .mask_out(mask_out),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_idx(wr_idx), .done(done), .count(count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0, fails = 0;
    logic [63:0] ev [64];
    int          dest [64];
    int          wr_n, done_n, got_cnt;
    logic [63:0] got_mask;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            chk(elem_valid && elem_data != 64'd0, "R4", "write without nonzero element",
                longint'(elem_data), 1);
            dest[wr_addr] = int'(wr_idx);
            wr_n++;
        end
        if (rst_n && done) begin
            done_n++;
            got_cnt  = int'(count);
            got_mask = mask_out;
        end
    end

    task automatic run_vec(input int len, input int gap_pct, input bit poke, input string tag);
        logic [63:0] exp_mask;
        int          exp_idx [64];
        int          n;
        exp_mask = '0;
        n = 0;
        for (int i = 0; i < len; i++) begin
            if (ev[i] != 64'd0) begin
                exp_mask[i] = 1'b1;
                exp_idx[n] = i;
                n++;
            end
        end
        for (int j = 0; j < 64; j++) dest[j] = -1;
        wr_n = 0;
        done_n = 0;
        @(posedge clk); #1;
        start = 1'b1;
        vlen  = 7'(len);
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            while ($urandom_range(99) < gap_pct) begin
                elem_valid = 1'b0;
                elem_data  = {$urandom, $urandom};
                if (poke) begin
                    start = 1'b1;
                    vlen  = 7'd3;
                end
                @(posedge clk); #1;
                start = 1'b0;
            end
            elem_valid = 1'b1;
            elem_data  = ev[i];
            @(posedge clk); #1;
        end
        elem_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(done_n == 1, "R5", {tag, " done pulses"}, done_n, 1);
        chk(got_cnt == n, "R5", {tag, " count"}, got_cnt, n);
        chk(got_mask == exp_mask, "R1", {tag, " mask"}, longint'(got_mask), longint'(exp_mask));
        chk(wr_n == n, "R4", {tag, " write total"}, wr_n, n);
        for (int j = 0; j < 64; j++) begin
            if (j < n) chk(dest[j] == exp_idx[j], "R3", {tag, " packed index"}, dest[j], exp_idx[j]);
            else       chk(dest[j] == -1, "R3", {tag, " entry beyond count"}, dest[j], -1);
        end
    endtask

    initial begin
        int ex [14];
        int pos_ex [7];
        void'($urandom(32'd20240611));
        ex     = '{0, -1, 0, 5, -15, 0, 0, 24, -7, 13, 0, -17, 0, 0};
        pos_ex = '{1, 3, 4, 7, 8, 9, 11};
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(mask_out == 64'd0, "R10", "mask after reset", longint'(mask_out), 0);
        chk(!wr_en, "R10", "wr_en after reset", wr_en, 0);
        chk(!done, "R10", "done after reset", done, 0);

        // R2 worked example
        for (int i = 0; i < 64; i++) ev[i] = 64'd0;
        for (int i = 0; i < 14; i++) ev[i] = 64'(longint'(ex[i]));
        run_vec(14, 0, 1'b0, "R2");
        chk(got_cnt == 7, "R2", "example count", got_cnt, 7);
        for (int k = 0; k < 7; k++)
            chk(dest[k] == pos_ex[k], "R2", "example index", dest[k], pos_ex[k]);

        // R6 zero length
        run_vec(0, 0, 1'b0, "R6");
        chk(got_cnt == 0 && got_mask == 64'd0, "R6", "zero length result", got_cnt, 0);

        // R9 full length, all nonzero
        for (int i = 0; i < 64; i++) ev[i] = 64'(i + 1);
        run_vec(64, 0, 1'b0, "R9");
        chk(got_cnt == 64, "R9", "full count", got_cnt, 64);

        // all zero, full length
        for (int i = 0; i < 64; i++) ev[i] = 64'd0;
        run_vec(64, 0, 1'b0, "R1-zero");

        // R1 mask bits above length stay clear even though later elements are nonzero
        for (int i = 0; i < 64; i++) ev[i] = 64'hFFFF_0000_0000_0001;
        ev[2] = 64'd0;
        run_vec(5, 0, 1'b0, "R1");

        // R8 stalls between elements
        for (int i = 0; i < 64; i++) ev[i] = ($urandom_range(1) == 1) ? {$urandom, $urandom} : 64'd0;
        run_vec(40, 60, 1'b0, "R8");

        // R7 start pulses while a run is busy
        for (int i = 0; i < 64; i++) ev[i] = ($urandom_range(1) == 1) ? 64'h8000_0000_0000_0000 : 64'd0;
        run_vec(20, 40, 1'b1, "R7");

        // constrained random
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < 64; i++)
                ev[i] = ($urandom_range(99) < 50) ? 64'd0 : {$urandom, $urandom};
            run_vec(int'($urandom_range(64)), int'($urandom_range(30)), 1'b0, "rand");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule